// File: doc/BRIEF.md
# Host Bridge Window Translation Register File

This block sits beside a host-to-PCI bridge and holds its address-window setup. A 32-bit register port gives software access to eight words: three inbound window-mapping words, three secondary mapping words, an identity word and a flag word. Reads return data one cycle after the request.

The same block also translates addresses, with no clock in that path. The caller names a window with `xl_sel` and gives an offset inside it. The block returns the PCI address and a hit flag. Selects 0 to 2 pick the three memory windows, and select 3 picks the fixed I/O window.

The top parameter `VARIANT_MASKED` chooses how a mapping word forms a window base:
- **Nibble variant (0):** a 4-bit field picks the top nibble of the base.
- **Masked variant (1):** the upper bits of the word, masked by the window size, form the base.

The window sizes also depend on the variant.

Top module: `hb_xlate_regs`

## Requirements
- R1: Full-word writes store all 32 bits, and a later full-word read returns them. The register at each byte offset is:
  - 0x00, 0x04, 0x08: mapping words for windows 0, 1 and 2.
  - 0x0C: identity word.
  - 0x10: flag word.
  - 0x14, 0x18, 0x1C: secondary words 0, 1 and 2.
- R2: `reg_rdata` takes the read value on the clock edge that samples `reg_rd`. It keeps that value on every edge where `reg_rd` is low.
- R3: An access is valid only when `reg_be` is 4'hF. A write with any other `reg_be` changes no register. A read with any other `reg_be` returns zero.
- R4: A read at any offset not listed in R1 returns zero, and this includes unaligned offsets. A write at such an offset changes no register.
- R5: Reset clears all eight registers to zero.
- R6: With `VARIANT_MASKED`=0, a memory window's base is bits [3:0] of its mapping word shifted left by 28. The window sizes are 0x0C000000, 0x10000000 and 0x10000000.
- R7: With `VARIANT_MASKED`=1, a memory window's base is its mapping word ANDed with the inverse of (size-1). The window sizes are 0x01000000, 0x04000000 and 0x08000000.
- R8: `xl_sel`=3 selects the I/O window in both variants. Its base is 0 and its size is 0x100000.
- R9: `xl_hit` is 1 exactly when `xl_offset` is below the selected window's size. On a hit, `xl_addr` is the base plus the offset. On a miss, `xl_addr` is 0.
- R10: A new mapping word affects translation only after the clock edge that stores it. In the cycle of the write itself, the old base still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF forms a valid access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| xl_sel | input | 2 | Window select: 0 to 2 memory windows, 3 I/O window |
| xl_offset | input | 32 | Local offset inside the selected window |
| xl_addr | output | 32 | Translated PCI address, or 0 on a miss |
| xl_hit | output | 1 | Offset lies inside the selected window |

## Verification
Read data is due one clock edge after `reg_rd` is sampled. The driver sets up each read between edges and queues the expected word. The monitor pops that word just after the following rising edge and compares it.

Translation has no register in its path. It is checked a short delay after its inputs change, with no edge in between. A mapping write is checked twice: once before its storing edge, where the old base is expected, and once after it, where the new base is expected.

Both variants are built side by side and driven with the same stimulus. Each translation is therefore compared against both base rules at once.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_WIN = 3;

    // How a translator forms its window base
    typedef enum logic [1:0] {
        BASE_NIBBLE = 2'd0,
        BASE_MASKED = 2'd1,
        BASE_FIXED  = 2'd2
    } base_mode_e;

    // Register offsets; software depends on these positions
    localparam logic [7:0] OFS_MAP0  = 8'h00;
    localparam logic [7:0] OFS_IDENT = 8'h0C;
    localparam logic [7:0] OFS_FLAG  = 8'h10;
    localparam logic [7:0] OFS_SEC0  = 8'h14;

    localparam logic [DATA_W-1:0] IO_WIN_SIZE = 32'h0010_0000;

    typedef struct packed {
        logic [NUM_WIN-1:0][DATA_W-1:0] map_w;
        logic [NUM_WIN-1:0][DATA_W-1:0] sec_w;
        logic [DATA_W-1:0]              ident;
        logic [DATA_W-1:0]              flag;
        logic [DATA_W-1:0]              rdata;
    } bank_t;

    typedef struct packed {
        logic [NUM_WIN-1:0] map_hit;
        logic [NUM_WIN-1:0] sec_hit;
        logic               ident_hit;
        logic               flag_hit;
        logic               full_word;
    } dec_t;

    function automatic logic [DATA_W-1:0] win_size(input bit masked, input int idx);
        logic [DATA_W-1:0] sz;
        if (masked) begin
            sz = (idx == 0) ? 32'h0100_0000 :
                 (idx == 1) ? 32'h0400_0000 : 32'h0800_0000;
        end else begin
            sz = (idx == 0) ? 32'h0C00_0000 : 32'h1000_0000;
        end
        return sz;
    endfunction

endpackage

// File: rtl/hbx_addr_dec.sv
module hbx_addr_dec
    import hbx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output dec_t              dec
);
    localparam int UPPER_W = ADDR_W - 8;

    logic upper_zero;
    logic [7:0] low_ofs;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:8] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign low_ofs = addr[7:0];

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            assign dec.map_hit[w] = upper_zero && (low_ofs == OFS_MAP0 + 8'(4 * w));
            assign dec.sec_hit[w] = upper_zero && (low_ofs == OFS_SEC0 + 8'(4 * w));
        end
    endgenerate

    assign dec.ident_hit = upper_zero && (low_ofs == OFS_IDENT);
    assign dec.flag_hit  = upper_zero && (low_ofs == OFS_FLAG);
    assign dec.full_word = (be == 4'hF);

endmodule

// File: rtl/hbx_regbank.sv
module hbx_regbank
    import hbx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic                           rd,
    input  dec_t                           dec,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_WIN-1:0][DATA_W-1:0] map_words
);
    bank_t bank_d, bank_q;
    logic [DATA_W-1:0] rd_val;

    // OR-reduce the selected word; a miss leaves zero
    always_comb begin
        rd_val = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (dec.map_hit[w]) rd_val = rd_val | bank_q.map_w[w];
            if (dec.sec_hit[w]) rd_val = rd_val | bank_q.sec_w[w];
        end
        if (dec.ident_hit) rd_val = rd_val | bank_q.ident;
        if (dec.flag_hit)  rd_val = rd_val | bank_q.flag;
        if (!dec.full_word) rd_val = '0;
    end

    always_comb begin
        bank_d = bank_q;
        if (wr && dec.full_word) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (dec.map_hit[w]) bank_d.map_w[w] = wdata;
                if (dec.sec_hit[w]) bank_d.sec_w[w] = wdata;
            end
            if (dec.ident_hit) bank_d.ident = wdata;
            if (dec.flag_hit)  bank_d.flag  = wdata;
        end
        if (rd) bank_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rdata     = bank_q.rdata;
    assign map_words = bank_q.map_w;

endmodule

// File: rtl/hbx_win_xlate.sv
module hbx_win_xlate
    import hbx_pkg::*;
#(
    parameter base_mode_e        MODE     = BASE_NIBBLE,
    parameter logic [DATA_W-1:0] WIN_SIZE = 32'h1000_0000
) (
    input  logic [DATA_W-1:0] map_word,
    input  logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] addr,
    output logic              hit
);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~(WIN_SIZE - 32'd1);

    logic [DATA_W-1:0] base;

    generate
        if (MODE == BASE_NIBBLE) begin : g_nib
            logic unused_hi;
            assign unused_hi = ^map_word[DATA_W-1:4];
            assign base = {map_word[3:0], {(DATA_W-4){1'b0}}};
        end else if (MODE == BASE_MASKED) begin : g_msk
            assign base = map_word & KEEP_MASK;
        end else begin : g_fix
            logic unused_all;
            assign unused_all = ^map_word;
            assign base = '0;
        end
    endgenerate

    assign hit  = (offset < WIN_SIZE);
    assign addr = hit ? (base + offset) : '0;

endmodule

// File: rtl/hb_xlate_regs.sv
module hb_xlate_regs
    import hbx_pkg::*;
#(
    parameter bit VARIANT_MASKED = 1'b0,
    parameter int ADDR_W         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        xl_sel,
    input  logic [31:0]       xl_offset,
    output logic [31:0]       xl_addr,
    output logic              xl_hit
);
    localparam base_mode_e MEM_MODE = VARIANT_MASKED ? BASE_MASKED : BASE_NIBBLE;
    localparam int         N_XL     = NUM_WIN + 1;

    dec_t dec;
    logic [NUM_WIN-1:0][DATA_W-1:0] map_words;
    logic [N_XL-1:0][DATA_W-1:0]    win_addr;
    logic [N_XL-1:0]                win_hit;

    hbx_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (reg_addr),
        .be   (reg_be),
        .dec  (dec)
    );

    hbx_regbank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .dec       (dec),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .map_words (map_words)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_mem
            hbx_win_xlate #(
                .MODE     (MEM_MODE),
                .WIN_SIZE (win_size(VARIANT_MASKED, w))
            ) xl_i (
                .map_word (map_words[w]),
                .offset   (xl_offset),
                .addr     (win_addr[w]),
                .hit      (win_hit[w])
            );
        end
    endgenerate

    hbx_win_xlate #(
        .MODE     (BASE_FIXED),
        .WIN_SIZE (IO_WIN_SIZE)
    ) io_xl_i (
        .map_word ('0),
        .offset   (xl_offset),
        .addr     (win_addr[NUM_WIN]),
        .hit      (win_hit[NUM_WIN])
    );

    assign xl_addr = win_addr[xl_sel];
    assign xl_hit  = win_hit[xl_sel];

endmodule

// File: rtl/hbx_chk.sv
module hbx_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [3:0]        reg_be,
    input logic [31:0]       reg_rdata,
    input logic [1:0]        xl_sel,
    input logic [31:0]       xl_offset,
    input logic [31:0]       xl_addr,
    input logic              xl_hit
);
    logic listed;
    assign listed = (reg_addr == ADDR_W'(8'h00)) || (reg_addr == ADDR_W'(8'h04)) ||
                    (reg_addr == ADDR_W'(8'h08)) || (reg_addr == ADDR_W'(8'h0C)) ||
                    (reg_addr == ADDR_W'(8'h10)) || (reg_addr == ADDR_W'(8'h14)) ||
                    (reg_addr == ADDR_W'(8'h18)) || (reg_addr == ADDR_W'(8'h1C));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R3
    part_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_be != 4'hF) |=> (reg_rdata == 32'd0));

    // R4
    unlisted_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !listed) |=> (reg_rdata == 32'd0));

    // R9
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_addr == 32'd0));

    // R8
    io_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_sel == 2'd3) |-> (xl_hit == (xl_offset < 32'h0010_0000)) &&
                             (!xl_hit || xl_addr == xl_offset));

    // R10
    map_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!reg_wr) && $stable(xl_sel) && $stable(xl_offset)) |-> $stable(xl_addr));

endmodule

bind hb_xlate_regs hbx_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .reg_rdata (reg_rdata),
    .xl_sel    (xl_sel),
    .xl_offset (xl_offset),
    .xl_addr   (xl_addr),
    .xl_hit    (xl_hit)
);

// File: tb/hb_xlate_regs_tb_top.sv
`timescale 1ns/1ps
module hb_xlate_regs_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [3:0]    reg_be = 4'hF;
    logic [31:0]   reg_wdata = '0;
    logic [1:0]    xl_sel = '0;
    logic [31:0]   xl_offset = '0;
    logic [31:0]   rdata_n, rdata_m, addr_n, addr_m;
    logic          hit_n, hit_m;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    // bench copy of the eight words, indexed by offset/4
    logic [31:0] model [8];

    always #2 clk = ~clk;

    hb_xlate_regs #(.VARIANT_MASKED(1'b0), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_n), .xl_sel(xl_sel), .xl_offset(xl_offset),
        .xl_addr(addr_n), .xl_hit(hit_n));

    hb_xlate_regs #(.VARIANT_MASKED(1'b1), .ADDR_W(AW)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_m), .xl_sel(xl_sel), .xl_offset(xl_offset),
        .xl_addr(addr_m), .xl_hit(hit_m));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] size_of(input bit masked, input int sel);
        if (sel == 3) return 32'h0010_0000;
        if (masked) return (sel == 0) ? 32'h0100_0000 : (sel == 1) ? 32'h0400_0000 : 32'h0800_0000;
        return (sel == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    endfunction

    function automatic logic [32:0] exp_xl(input bit masked, input int sel, input logic [31:0] off);
        logic [31:0] sz, base;
        sz = size_of(masked, sel);
        if (sel == 3)    base = 32'd0;
        else if (masked) base = model[sel] & ~(sz - 32'd1);
        else             base = {model[sel][3:0], 28'd0};
        if (off < sz) return {1'b1, base + off};
        return 33'd0;
    endfunction

    function automatic int slot_of(input logic [AW-1:0] a);
        if (a[AW-1:5] == '0 && a[1:0] == 2'b00) return int'(a[4:2]);
        return -1;
    endfunction

    // scoreboard monitor: read data is due just after the sampling edge
    always @(posedge clk) begin
        if (rst_n && reg_rd) begin
            #1;
            if (sb_q.size() == 0) begin
                check("R2 unexpected read", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({it.req, " nibble"}, rdata_n, it.exp);
                check({it.req, " masked"}, rdata_m, it.exp);
            end
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
        if (be == 4'hF && slot_of(a) >= 0) model[slot_of(a)] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [3:0] be, input string req);
        item_t it;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_be = be;
        it.req = req;
        it.exp = (be == 4'hF && slot_of(a) >= 0) ? model[slot_of(a)] : 32'd0;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0; reg_be = 4'hF;
    endtask

    task automatic chk_xl(input int sel, input logic [31:0] off, input string req);
        logic [32:0] en, em;
        xl_sel = 2'(sel); xl_offset = off;
        #0.5;
        en = exp_xl(1'b0, sel, off);
        em = exp_xl(1'b1, sel, off);
        check({req, " nibble hit"},  {31'd0, hit_n}, {31'd0, en[32]});
        check({req, " nibble addr"}, addr_n, en[31:0]);
        check({req, " masked hit"},  {31'd0, hit_m}, {31'd0, em[32]});
        check({req, " masked addr"}, addr_m, em[31:0]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: every word reads zero after reset, bases zero
        for (int i = 0; i < 8; i++) do_read(AW'(4 * i), 4'hF, "R5 reset value");
        @(negedge clk);
        chk_xl(0, 32'h0000_1000, "R5 reset base");

        // R1: distinct words at every listed offset
        for (int i = 0; i < 8; i++) do_write(AW'(4 * i), 32'hA5000000 ^ (32'h01010101 * (i + 1)), 4'hF);
        for (int i = 0; i < 8; i++) do_read(AW'(4 * i), 4'hF, "R1 readback");

        // R2: read data holds while no read is requested
        do_read(AW'(8'h10), 4'hF, "R2 read");
        repeat (3) @(negedge clk);
        check("R2 hold nibble", rdata_n, model[4]);
        check("R2 hold masked", rdata_m, model[4]);

        // R3: partial byte enables
        do_write(AW'(8'h0C), 32'hDEAD_BEEF, 4'b0011);
        do_read(AW'(8'h0C), 4'hF, "R3 partial write ignored");
        do_read(AW'(8'h0C), 4'b1110, "R3 partial read zero");

        // R4: unlisted and unaligned offsets
        do_write(AW'(8'h20), 32'h1234_5678, 4'hF);
        do_write(AW'(8'h02), 32'h1234_5678, 4'hF);
        do_write(AW'(12'h100), 32'h1234_5678, 4'hF);
        do_read(AW'(8'h20), 4'hF, "R4 unlisted read");
        do_read(AW'(8'h02), 4'hF, "R4 unaligned read");
        do_read(AW'(12'h114), 4'hF, "R4 high offset read");
        for (int i = 0; i < 8; i++) do_read(AW'(4 * i), 4'hF, "R4 words untouched");

        // R6/R7: base rule per variant, several mapping words
        do_write(AW'(8'h00), 32'h1234_5678, 4'hF);
        do_write(AW'(8'h04), 32'hFEDC_BA93, 4'hF);
        do_write(AW'(8'h08), 32'h0F0F_F0F1, 4'hF);
        for (int w = 0; w < 3; w++) begin
            chk_xl(w, 32'd0, "R6 R7 base");
            chk_xl(w, 32'h0012_3456, "R6 R7 offset add");
        end

        // R9: edges of each window for both variants
        for (int w = 0; w < 4; w++) begin
            chk_xl(w, size_of(1'b0, w) - 32'd1, "R9 last nibble-size");
            chk_xl(w, size_of(1'b0, w),         "R9 at nibble-size");
            chk_xl(w, size_of(1'b1, w) - 32'd1, "R9 last masked-size");
            chk_xl(w, size_of(1'b1, w),         "R9 at masked-size");
        end
        chk_xl(1, 32'hFFFF_FFFF, "R9 far offset");

        // R8: I/O window ignores mapping words
        chk_xl(3, 32'h0000_0ABC, "R8 io low");
        chk_xl(3, 32'h000F_FFFF, "R8 io top");

        // R10: old base during the write cycle, new base after the edge
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(8'h04); reg_wdata = 32'h0765_4327; reg_be = 4'hF;
        chk_xl(1, 32'h0000_0040, "R10 before edge");
        @(negedge clk);
        reg_wr = 1'b0;
        model[1] = 32'h0765_4327;
        chk_xl(1, 32'h0000_0040, "R10 after edge");

        // R5: reset again clears the words
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        for (int i = 0; i < 8; i++) do_read(AW'(4 * i), 4'hF, "R5 second reset");
        chk_xl(2, 32'h0000_0100, "R5 base after reset");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) check("R2 pending reads", 32'(sb_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule